// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Unit

This block keeps the pointers of a receive buffer descriptor ring that a host and a DMA engine share. The host programs a 256-byte-aligned ring base and a producer index through a small 32-bit register port. The producer index points one past the last descriptor the host has made ready. The DMA engine raises a request whenever it wants the next descriptor. In the same cycle it gets a grant and the byte address to fetch. On each grant the block advances its consumer index, wrapping at a parameterised ring length.

Frames are bracketed by strobes from the DMA side. A frame-start strobe records the consumer index. A frame-good strobe closes the frame and keeps the advanced index. A frame-bad strobe on an open frame puts the consumer back to the recorded index, so the buffers of the failed frame are handed out again. The host may overwrite the consumer index, but only while a write-enable bit in a control register is set.

Top module: `rxring_ptr_unit`

## Requirements
- R1: After synchronous reset the base, pointer and control registers read zero, and a request is not granted.
- R2: Register select 0 holds the ring base. Write bits 31:8 are stored, and bits 7:0 always read as zero.
- R3: Register select 1 carries the producer index in bits 10:0, written by the host. Bits 31:27 and 15:11 ignore writes and read zero.
- R4: Bits 26:16 of register select 1 read the consumer index. A host write loads those bits into the consumer index only while bit 0 of register select 2 (the consumer write enable) is 1. Otherwise the consumer field of the write is ignored.
- R5: `desc_grant` is high in the same cycle as `desc_req` exactly when the consumer index differs from the producer index and no rollback or consumer write takes place in that cycle. Equal indices mean the ring is empty.
- R6: Each grant advances the consumer index by one at the next edge. From RING_LEN-1 it wraps to 0. Without a grant, rollback or consumer write, the index holds.
- R7: `desc_addr` equals the base address plus the current consumer index times DESC_BYTES.
- R8: `frame_start` records the consumer index and opens a frame. `frame_bad` on an open frame restores the recorded index at the next edge and closes the frame.
- R9: `frame_good` closes the frame and keeps the advanced index. A `frame_bad` with no open frame has no effect.
- R10: If several updates meet in one cycle, rollback wins over a host consumer write, and a host consumer write wins over a grant. A grant is not given in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 base, 1 pointers, 2 control |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| desc_req | input | 1 | DMA asks for the next descriptor |
| desc_grant | output | 1 | Request accepted this cycle |
| desc_addr | output | 32 | Byte address of the descriptor at the consumer index |
| frame_start | input | 1 | First descriptor of a frame is about to be taken |
| frame_good | input | 1 | Frame completed correctly |
| frame_bad | input | 1 | Frame failed; reuse its buffers |

## Verification
`desc_grant` and `desc_addr` are combinational, so the bench drives a request just after a falling edge and samples them 1 ns later, in the same cycle. Register writes, consumer advances, snapshots and rollbacks all take effect at the next rising edge. The bench therefore reads `host_rdata` only after that edge, at the following falling edge, when the new value is already visible. An exhaustive sweep over every consumer and producer start pair of an 8-entry ring predicts the number of grants and each fetch address with modular arithmetic.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int IDX_W = 11;

    typedef logic [IDX_W-1:0] ring_idx_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_PTRS = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic req;
        logic frame_start;
        logic frame_good;
        logic frame_bad;
    } dma_evt_t;

    typedef struct packed {
        logic      wr;
        ring_idx_t val;
    } cons_load_t;

    // Next ring position with wrap at the ring length
    function automatic ring_idx_t idx_next(ring_idx_t i, int unsigned len);
        return (i == ring_idx_t'(len - 1)) ? '0 : ring_idx_t'(i + 1'b1);
    endfunction

    // Pointer word layout: consumer 26:16, producer 10:0, rest zero
    function automatic logic [31:0] ptr_word(ring_idx_t cons, ring_idx_t prod);
        return {5'b0, cons, 5'b0, prod};
    endfunction

endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
    import rxring_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    input  ring_idx_t   cons_idx,
    output logic [23:0] base_hi,
    output ring_idx_t   prod_idx,
    output logic        cons_we_en,
    output cons_load_t  cons_load,
    output logic [31:0] host_rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(host_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi    <= '0;
            prod_idx   <= '0;
            cons_we_en <= 1'b0;
        end else if (host_we) begin
            case (sel)
                SEL_BASE: base_hi    <= host_wdata[31:8];
                SEL_PTRS: prod_idx   <= host_wdata[10:0];
                SEL_CTRL: cons_we_en <= host_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cons_load.wr  = host_we && (sel == SEL_PTRS) && cons_we_en;
        cons_load.val = host_wdata[26:16];
    end

    always_comb begin
        case (sel)
            SEL_BASE: host_rdata = {base_hi, 8'h00};
            SEL_PTRS: host_rdata = ptr_word(cons_idx, prod_idx);
            SEL_CTRL: host_rdata = {31'b0, cons_we_en};
            default:  host_rdata = '0;
        endcase
    end

    // R2: low byte of the base register never reads non-zero
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_BASE) |-> (host_rdata[7:0] == 8'h00));

    // R3: reserved pointer bits read zero
    assert_ptr_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_PTRS) |-> (host_rdata[31:27] == 5'b0 && host_rdata[15:11] == 5'b0));

    // R3: producer written by host appears next cycle
    assert_prod_load_R3: assert property (@(posedge clk) disable iff (rst)
        (host_we && sel == SEL_PTRS) |=> (prod_idx == $past(host_wdata[10:0])));

endmodule

// File: rtl/rxring_consumer.sv
module rxring_consumer
    import rxring_pkg::*;
#(
    parameter int unsigned RING_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  dma_evt_t   evt,
    input  ring_idx_t  prod_idx,
    input  cons_load_t cons_load,
    output ring_idx_t  cons_idx,
    output logic       grant,
    output logic       rollback
);

    ring_idx_t snap_q;
    logic      frame_open_q;
    logic      empty;

    assign empty    = (cons_idx == prod_idx);
    assign rollback = evt.frame_bad && frame_open_q;
    assign grant    = evt.req && !empty && !rollback && !cons_load.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q       <= '0;
            frame_open_q <= 1'b0;
        end else if (evt.frame_start) begin
            snap_q       <= cons_idx;
            frame_open_q <= 1'b1;
        end else if (evt.frame_good || rollback) begin
            frame_open_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cons_idx <= '0;
        end else if (rollback) begin
            cons_idx <= snap_q;
        end else if (cons_load.wr) begin
            cons_idx <= cons_load.val;
        end else if (grant) begin
            cons_idx <= idx_next(cons_idx, RING_LEN);
        end
    end

    // R5: no grant out of an empty ring
    assert_grant_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        grant |-> (cons_idx != prod_idx));

    // R6: a grant moves the consumer by exactly one ring step
    assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
        grant |=> (cons_idx == idx_next($past(cons_idx), RING_LEN)));

    // R6: idle cycles leave the consumer alone
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt.req && !evt.frame_bad && !cons_load.wr) |=> $stable(cons_idx));

    // R8: a bad frame brings back the recorded index
    assert_rollback_R8: assert property (@(posedge clk) disable iff (rst)
        rollback |=> (cons_idx == $past(snap_q)));

    // R10: no grant while a higher-priority update happens
    assert_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (rollback || cons_load.wr) |-> !grant);

endmodule

// File: rtl/rxring_addr.sv
module rxring_addr
    import rxring_pkg::*;
#(
    parameter int unsigned DESC_BYTES = 16
) (
    input  logic [23:0] base_hi,
    input  ring_idx_t   cons_idx,
    output logic [31:0] fetch_addr
);

    localparam bit          IS_POW2 = (DESC_BYTES & (DESC_BYTES - 1)) == 0;
    localparam int unsigned SHIFT   = $clog2(DESC_BYTES);

    logic [31:0] offset;

    generate
        if (IS_POW2) begin : g_shift
            assign offset = 32'(cons_idx) << SHIFT;
        end else begin : g_mult
            assign offset = 32'(cons_idx) * 32'(DESC_BYTES);
        end
    endgenerate

    assign fetch_addr = {base_hi, 8'h00} + offset;

endmodule

// File: rtl/rxring_ptr_unit.sv
module rxring_ptr_unit
    import rxring_pkg::*;
#(
    parameter int unsigned RING_LEN   = 16,
    parameter int unsigned DESC_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        desc_req,
    output logic        desc_grant,
    output logic [31:0] desc_addr,
    input  logic        frame_start,
    input  logic        frame_good,
    input  logic        frame_bad
);

    logic [23:0] base_hi;
    ring_idx_t   prod_idx;
    ring_idx_t   cons_idx;
    logic        cons_we_en;
    logic        rollback;
    cons_load_t  cons_load;
    dma_evt_t    evt;

    assign evt = '{req: desc_req, frame_start: frame_start,
                   frame_good: frame_good, frame_bad: frame_bad};

    rxring_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .cons_idx   (cons_idx),
        .base_hi    (base_hi),
        .prod_idx   (prod_idx),
        .cons_we_en (cons_we_en),
        .cons_load  (cons_load),
        .host_rdata (host_rdata)
    );

    rxring_consumer #(.RING_LEN(RING_LEN)) u_cons (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .prod_idx  (prod_idx),
        .cons_load (cons_load),
        .cons_idx  (cons_idx),
        .grant     (desc_grant),
        .rollback  (rollback)
    );

    rxring_addr #(.DESC_BYTES(DESC_BYTES)) u_addr (
        .base_hi    (base_hi),
        .cons_idx   (cons_idx),
        .fetch_addr (desc_addr)
    );

    // R4: a pointer write with the enable clear leaves the consumer alone
    assert_cons_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel == 2'd1 && !cons_we_en && !desc_grant && !rollback)
            |=> $stable(cons_idx));

    // R7: fetch address lies on or above the ring base
    assert_addr_above_base_R7: assert property (@(posedge clk) disable iff (rst)
        desc_grant |-> (desc_addr >= {base_hi, 8'h00}));

endmodule

// File: tb/sim_rxring_ptr_unit.sv
module sim_rxring_ptr_unit;

    localparam int unsigned LEN  = 8;
    localparam int unsigned DSZ  = 16;
    localparam logic [31:0] BASE = 32'h1234_5600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        desc_req = 1'b0;
    logic        desc_grant;
    logic [31:0] desc_addr;
    logic        frame_start = 1'b0;
    logic        frame_good = 1'b0;
    logic        frame_bad = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rxring_ptr_unit #(.RING_LEN(LEN), .DESC_BYTES(DSZ)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .desc_req(desc_req), .desc_grant(desc_grant), .desc_addr(desc_addr),
        .frame_start(frame_start), .frame_good(frame_good), .frame_bad(frame_bad)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        host_sel = sel;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic set_ptrs(input int c, input int p);
        wr(2'd2, 32'd1);
        wr(2'd1, (32'(c) << 16) | 32'(p));
        wr(2'd2, 32'd0);
    endtask

    function automatic logic [31:0] pw(input int c, input int p);
        return (32'(c) << 16) | 32'(p);
    endfunction

    // One DMA cycle: drive at the falling edge, check combinational grant
    task automatic dma(input logic rq, input logic st, input logic gd, input logic bd,
                       input logic exp_g, input string tag);
        @(negedge clk);
        desc_req = rq; frame_start = st; frame_good = gd; frame_bad = bd;
        #1;
        check(tag, 32'(desc_grant), 32'(exp_g));
    endtask

    task automatic idle();
        @(negedge clk);
        desc_req = 0; frame_start = 0; frame_good = 0; frame_bad = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, 32'h0, "R1 base");
        rd(2'd1, 32'h0, "R1 ptrs");
        rd(2'd2, 32'h0, "R1 ctrl");
        dma(1, 0, 0, 0, 0, "R1 no grant on empty ring");
        idle();

        // R2: base alignment
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'hFFFF_FF00, "R2 base low byte zero");
        wr(2'd0, BASE | 32'h0000_00A5);
        rd(2'd0, BASE, "R2 base value");

        // R3 and R4: enable clear, consumer field ignored, reserved zero
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'h0000_07FF, "R3 producer only, R4 consumer blocked");
        wr(2'd2, 32'd1);
        rd(2'd2, 32'd1, "R4 enable readback");
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'h07FF_07FF, "R4 consumer loaded with enable");
        wr(2'd1, pw(3, 5));
        wr(2'd2, 32'd0);
        wr(2'd1, pw(7, 6));
        rd(2'd1, pw(3, 6), "R4 consumer held after enable cleared");

        // R5, R6, R7: exhaustive sweep over start pairs
        for (int c = 0; c < int'(LEN); c++) begin
            for (int p = 0; p < int'(LEN); p++) begin
                int n;
                set_ptrs(c, p);
                n = (p - c + int'(LEN)) % int'(LEN);
                for (int k = 0; k <= int'(LEN); k++) begin
                    dma(1, 0, 0, 0, (k < n), "R5 grant vs occupancy");
                    if (k < n)
                        check("R7 fetch address", desc_addr,
                              BASE + 32'(((c + k) % int'(LEN)) * int'(DSZ)));
                end
                idle();
                rd(2'd1, pw(p, p), "R6 consumer after draining with wrap");
            end
        end

        // R8: bad frame rolls back
        set_ptrs(1, 7);
        dma(1, 1, 0, 0, 1, "R8 grant at frame start");
        dma(1, 0, 0, 0, 1, "R8 grant 2");
        dma(1, 0, 0, 0, 1, "R8 grant 3");
        idle();
        rd(2'd1, pw(4, 7), "R6 advanced during frame");
        dma(0, 0, 0, 1, 0, "R8 bad frame strobe");
        idle();
        rd(2'd1, pw(1, 7), "R8 consumer restored");
        check("R8 address after rollback", desc_addr, BASE + 32'(1 * DSZ));

        // R9: good frame commits, later bad ignored
        dma(1, 1, 0, 0, 1, "R9 grant at frame start");
        dma(1, 0, 0, 0, 1, "R9 grant 2");
        dma(0, 0, 1, 0, 0, "R9 good frame");
        dma(0, 0, 0, 1, 0, "R9 stray bad frame");
        idle();
        rd(2'd1, pw(3, 7), "R9 consumer kept after good frame");

        // R10: rollback beats host write beats grant
        dma(1, 1, 0, 0, 1, "R10 open frame");
        idle();
        wr(2'd2, 32'd1);
        @(negedge clk);
        host_we = 1; host_sel = 2'd1; host_wdata = pw(6, 7);
        desc_req = 1; frame_bad = 1;
        #1;
        check("R10 no grant during rollback", 32'(desc_grant), 32'd0);
        @(negedge clk);
        host_we = 0; desc_req = 0; frame_bad = 0;
        rd(2'd1, pw(3, 7), "R10 rollback wins over host write");
        @(negedge clk);
        host_we = 1; host_sel = 2'd1; host_wdata = pw(5, 7); desc_req = 1;
        #1;
        check("R10 no grant during host write", 32'(desc_grant), 32'd0);
        @(negedge clk);
        host_we = 0; desc_req = 0;
        rd(2'd1, pw(5, 7), "R10 host write wins over grant");
        wr(2'd2, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule